// File: doc/BRIEF.md
# SPI Command Register Slave

This block is the serial front end of a sixteen-channel low-side switch controller. A host talks to it over a four-wire SPI link: each 24-bit command word enters most significant bit first on the data input, sampled on falling SCLK edges. While it shifts in, the 24-bit fault status word goes out on the data output, changing on rising SCLK edges. The status word is captured from the fault block in parallel when chip select falls. When chip select rises, the block checks that a whole number of words arrived. It then decodes the top six bits of the word left in its shift register and writes one configuration register, or performs a soft reset of part of the register set.

The shift path runs first-in first-out, so several devices can share one chip select in a daisy chain. A device then passes on, after its own status word, exactly the bits it received. SCLK, chip select and the data input are brought into the system clock domain through synchronisers, and edges are found on the synchronised copies. The system clock must run at least four times the SPI bit rate. The configuration registers drive the output stage directly: per-channel on/off, open-load test current enable, fast short-circuit trip disable, PWM select and PWM combine mode, plus two global fault-recovery bits.

Top module: `cmd_spi_slave`

## Requirements
- R1: After the system reset `rst` (synchronous, active high), every on/off, open-load enable, PWM select and PWM combine bit is 0, both global recovery bits are 0, and every fast-trip disable bit is 1.
- R2: Data bits are taken most significant bit first on falling SCLK edges. No register changes while chip select is low; a command takes effect only after chip select rises.
- R3: The opcode is word bits 23:18 and the channel data is bits 15:0. Opcode 0 writes on/off, 1 writes open-load enable, 3 writes fast-trip disable, 4 writes PWM select and 5 writes PWM combine mode (0 = AND with the PWM pin, 1 = OR).
- R4: Opcode 2 loads the thermal retry bit from word bit 17 and the over-voltage resume bit from word bit 16, and leaves all channel registers unchanged.
- R5: Opcode 6 returns on/off, fast-trip disable, PWM select and PWM combine to their R1 values, and leaves open-load enable and both global bits unchanged.
- R6: A word whose opcode is 7 or higher changes no register.
- R7: If the number of falling SCLK edges during a select is zero or not a multiple of 24, the rise of chip select changes no register.
- R8: The status word present when chip select falls is returned on the data output, most significant bit first. It is valid from the fall of chip select for bit 23, and each later bit appears after a rising SCLK edge.
- R9: In a 48-edge transfer the output returns the status word, then the first 24 bits that were shifted in; the last 24 bits shifted in are the word that is decoded.
- R10: While chip select is high the output drive enable is 0, and SCLK and data input activity changes neither the registers nor the framing of the next transfer.
- R11: Holding `pin_rst_n` low at a clock edge returns all registers to their R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the SCLK rate |
| rst | input | 1 | Synchronous active-high system reset |
| pin_rst_n | input | 1 | Active-low hard clear of all registers |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, idle low |
| mosi | input | 1 | SPI serial data in |
| miso | output | 1 | SPI serial data out |
| miso_en | output | 1 | Drive enable for the data output pad, 1 while selected |
| status_in | input | 24 | Fault status word from the fault block |
| out_on | output | 16 | Per-channel on/off command |
| ol_en | output | 16 | Per-channel open-load test current enable |
| thermal_retry | output | 1 | Retry after thermal shutdown when 1 |
| ov_resume | output | 1 | Resume previous outputs after over-voltage when 1 |
| fast_trip_off | output | 16 | Per-channel disable of fast short-circuit trip |
| pwm_sel | output | 16 | Per-channel PWM control select |
| pwm_or | output | 16 | Per-channel PWM combine mode, 1 = OR |

## Verification
Directed words for every opcode, with distinct channel patterns, show that the decode reaches the right register and only that one. Random words, some with reserved opcodes, are checked against a bench model of the register set. Short, long and empty selects tell a correctly counted frame from a miscounted one. SCLK activity with chip select high shows that the framing count is not disturbed. A register check in the middle of a held select shows that writes wait for the rise of chip select. A 48-bit daisy-chain transfer shows that the output order is status first, then the echoed input, and that the last word in is the one decoded.

// File: rtl/cmd_spi_pkg.sv
package cmd_spi_pkg;

    localparam int WORD_W = 24;
    localparam int CH_N   = 16;
    localparam int OP_W   = 6;
    localparam int OP_LSB = WORD_W - OP_W;

    typedef enum logic [OP_W-1:0] {
        OP_ONOFF  = 6'd0,
        OP_OLEN   = 6'd1,
        OP_GLOBAL = 6'd2,
        OP_FTRIP  = 6'd3,
        OP_PWMSEL = 6'd4,
        OP_PWMOR  = 6'd5,
        OP_SOFT   = 6'd6
    } opcode_e;

    typedef struct packed {
        logic [CH_N-1:0] out_on;
        logic [CH_N-1:0] ol_en;
        logic            thermal_retry;
        logic            ov_resume;
        logic [CH_N-1:0] fast_trip_off;
        logic [CH_N-1:0] pwm_sel;
        logic [CH_N-1:0] pwm_or;
    } cfg_t;

    function automatic cfg_t cfg_por();
        cfg_t c;
        c               = '0;
        c.fast_trip_off = '1;
        return c;
    endfunction

    function automatic logic [OP_W-1:0] op_field(input logic [WORD_W-1:0] w);
        return w[WORD_W-1:OP_LSB];
    endfunction

endpackage

// File: rtl/cmd_spi_sync.sv
module cmd_spi_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/cmd_spi_shifter.sv
module cmd_spi_shifter
    import cmd_spi_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pin_rst_n,
    input  logic         cs_act,
    input  logic         sck_s,
    input  logic         mosi_s,
    input  logic [W-1:0] status_in,
    output logic         so_q,
    output logic         commit,
    output logic [W-1:0] word
);
    localparam int CNT_W = $clog2(W);

    logic             cs_d, sck_d, seen;
    logic [W-1:0]     shift_q;
    logic [CNT_W-1:0] cnt;
    logic             cs_start, cs_end, sck_fall, sck_rise;

    assign cs_start = cs_act & ~cs_d;
    assign cs_end   = ~cs_act & cs_d;
    assign sck_fall = cs_act & sck_d & ~sck_s;
    assign sck_rise = cs_act & ~sck_d & sck_s;

    always_ff @(posedge clk) begin
        if (rst || !pin_rst_n) begin
            cs_d    <= 1'b0;
            sck_d   <= 1'b0;
            shift_q <= '0;
            cnt     <= '0;
            seen    <= 1'b0;
            so_q    <= 1'b0;
        end else begin
            cs_d  <= cs_act;
            sck_d <= sck_s;
            if (cs_start) begin
                shift_q <= status_in;
                so_q    <= status_in[W-1];
                cnt     <= '0;
                seen    <= 1'b0;
            end else begin
                if (sck_fall) begin
                    shift_q <= {shift_q[W-2:0], mosi_s};
                    cnt     <= (cnt == CNT_W'(W-1)) ? '0 : cnt + 1'b1;
                    seen    <= 1'b1;
                end
                if (sck_rise) so_q <= shift_q[W-1];
            end
        end
    end

    assign commit = cs_end && (cnt == '0) && seen;
    assign word   = shift_q;

    a_r8_status_msb: assert property (@(posedge clk) disable iff (rst || !pin_rst_n)
        cs_start |=> so_q == $past(status_in[W-1]));

    a_r10_idle_frozen: assert property (@(posedge clk) disable iff (rst || !pin_rst_n)
        !cs_act |=> $stable(shift_q));
endmodule

// File: rtl/cmd_spi_regs.sv
module cmd_spi_regs
    import cmd_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_rst_n,
    input  logic              commit,
    input  logic [WORD_W-1:0] word,
    output cfg_t              cfg_q
);
    logic [CH_N-1:0] data;
    logic [OP_W-1:0] op;

    assign data = word[CH_N-1:0];
    assign op   = op_field(word);

    always_ff @(posedge clk) begin
        if (rst || !pin_rst_n) begin
            cfg_q <= cfg_por();
        end else if (commit) begin
            case (op)
                OP_ONOFF:  cfg_q.out_on        <= data;
                OP_OLEN:   cfg_q.ol_en         <= data;
                OP_GLOBAL: begin
                    cfg_q.thermal_retry <= word[17];
                    cfg_q.ov_resume     <= word[16];
                end
                OP_FTRIP:  cfg_q.fast_trip_off <= data;
                OP_PWMSEL: cfg_q.pwm_sel       <= data;
                OP_PWMOR:  cfg_q.pwm_or        <= data;
                OP_SOFT: begin
                    cfg_q.out_on        <= '0;
                    cfg_q.fast_trip_off <= '1;
                    cfg_q.pwm_sel       <= '0;
                    cfg_q.pwm_or        <= '0;
                end
                default: ;
            endcase
        end
    end

    a_r1_por_values: assert property (@(posedge clk)
        rst |=> (cfg_q.fast_trip_off == '1 && cfg_q.out_on == '0 && cfg_q.pwm_sel == '0));

    a_r2_hold_without_commit: assert property (@(posedge clk) disable iff (rst || !pin_rst_n)
        !commit |=> $stable(cfg_q));

    a_r4_global_bits: assert property (@(posedge clk) disable iff (rst || !pin_rst_n)
        (commit && op == OP_GLOBAL) |=> (cfg_q.thermal_retry == $past(word[17])
                                         && $stable(cfg_q.out_on)));

    a_r5_soft_subset: assert property (@(posedge clk) disable iff (rst || !pin_rst_n)
        (commit && op == OP_SOFT) |=> (cfg_q.fast_trip_off == '1 && cfg_q.out_on == '0
                                       && $stable(cfg_q.ol_en) && $stable(cfg_q.ov_resume)));

    a_r6_reserved_ignored: assert property (@(posedge clk) disable iff (rst || !pin_rst_n)
        (commit && op > OP_W'(6)) |=> $stable(cfg_q));

    a_r11_pin_clear: assert property (@(posedge clk) disable iff (rst)
        !pin_rst_n |=> (cfg_q.ol_en == '0 && cfg_q.fast_trip_off == '1 && !cfg_q.thermal_retry));
endmodule

// File: rtl/cmd_spi_slave.sv
module cmd_spi_slave
    import cmd_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_en,
    input  logic [WORD_W-1:0] status_in,
    output logic [CH_N-1:0]   out_on,
    output logic [CH_N-1:0]   ol_en,
    output logic              thermal_retry,
    output logic              ov_resume,
    output logic [CH_N-1:0]   fast_trip_off,
    output logic [CH_N-1:0]   pwm_sel,
    output logic [CH_N-1:0]   pwm_or
);
    logic [2:0]        pins_s;
    logic              cs_act, commit;
    logic [WORD_W-1:0] word;
    cfg_t              cfg_q;

    cmd_spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({cs_n, sck, mosi}),
        .dout (pins_s)
    );

    assign cs_act = ~pins_s[2];

    cmd_spi_shifter #(.W(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .pin_rst_n (pin_rst_n),
        .cs_act    (cs_act),
        .sck_s     (pins_s[1]),
        .mosi_s    (pins_s[0]),
        .status_in (status_in),
        .so_q      (miso),
        .commit    (commit),
        .word      (word)
    );

    cmd_spi_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .pin_rst_n (pin_rst_n),
        .commit    (commit),
        .word      (word),
        .cfg_q     (cfg_q)
    );

    assign miso_en       = cs_act;
    assign out_on        = cfg_q.out_on;
    assign ol_en         = cfg_q.ol_en;
    assign thermal_retry = cfg_q.thermal_retry;
    assign ov_resume     = cfg_q.ov_resume;
    assign fast_trip_off = cfg_q.fast_trip_off;
    assign pwm_sel       = cfg_q.pwm_sel;
    assign pwm_or        = cfg_q.pwm_or;
endmodule

// File: tb/sim_cmd_spi_slave.sv
`timescale 1ns/1ps
module sim_cmd_spi_slave;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin_rst_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        mosi = 1'b0;
    logic        miso, miso_en;
    logic [23:0] status_in = 24'h0;
    logic [15:0] out_on, ol_en, fast_trip_off, pwm_sel, pwm_or;
    logic        thermal_retry, ov_resume;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    logic [15:0] e_on, e_ol, e_ft, e_ps, e_po;
    logic        e_tr, e_ov;

    always #2 clk = ~clk;

    cmd_spi_slave u0 (
        .clk(clk), .rst(rst), .pin_rst_n(pin_rst_n), .cs_n(cs_n), .sck(sck),
        .mosi(mosi), .miso(miso), .miso_en(miso_en), .status_in(status_in),
        .out_on(out_on), .ol_en(ol_en), .thermal_retry(thermal_retry),
        .ov_resume(ov_resume), .fast_trip_off(fast_trip_off),
        .pwm_sel(pwm_sel), .pwm_or(pwm_or)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_por();
        e_on = '0; e_ol = '0; e_ps = '0; e_po = '0; e_ft = '1; e_tr = 0; e_ov = 0;
    endtask

    task automatic model_apply(input logic [23:0] w);
        case (w[23:18])
            6'd0: e_on = w[15:0];
            6'd1: e_ol = w[15:0];
            6'd2: begin e_tr = w[17]; e_ov = w[16]; end
            6'd3: e_ft = w[15:0];
            6'd4: e_ps = w[15:0];
            6'd5: e_po = w[15:0];
            6'd6: begin e_on = '0; e_ft = '1; e_ps = '0; e_po = '0; end
            default: ;
        endcase
    endtask

    task automatic check_regs(input string req);
        chk(req, {out_on, ol_en, thermal_retry, ov_resume, fast_trip_off, pwm_sel, pwm_or},
                 {e_on, e_ol, e_tr, e_ov, e_ft, e_ps, e_po});
    endtask

    task automatic shift_bits(input int nbits, input logic [47:0] din, output logic [47:0] dout);
        dout = '0;
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = din[i];
            tick(2);
            sck = 1'b1;
            tick(4);
            dout[i] = miso;
            sck = 1'b0;
            tick(4);
        end
        tick(2);
    endtask

    task automatic frame(input int nbits, input logic [47:0] din, output logic [47:0] dout);
        cs_n = 1'b0;
        tick(6);
        shift_bits(nbits, din, dout);
        cs_n = 1'b1;
        tick(10);
    endtask

    task automatic word_frame(input string req, input logic [23:0] w);
        logic [47:0] d;
        logic [23:0] st;
        st = 24'($urandom);
        status_in = st;
        frame(24, {24'h0, w}, d);
        model_apply(w);
        check_regs(req);
        chk("R8 status readback", d[23:0], st);
    endtask

    initial begin
        logic [47:0] d;
        logic [23:0] w;
        logic [5:0]  op;
        void'($urandom(32'd2024));
        model_por();
        tick(5);
        rst = 1'b0;
        tick(3);
        check_regs("R1 reset values");
        chk("R10 drive off idle", miso_en, 1'b0);

        word_frame("R3 on/off write", {6'd0, 2'b00, 16'hA5C3});
        word_frame("R3 open-load write", {6'd1, 2'b11, 16'h0F0F});
        word_frame("R3 fast-trip write", {6'd3, 2'b00, 16'h1234});
        word_frame("R3 pwm select write", {6'd4, 2'b00, 16'hFF00});
        word_frame("R3 pwm combine write", {6'd5, 2'b01, 16'h8001});
        word_frame("R4 global 10", {6'd2, 2'b10, 16'hFFFF});
        word_frame("R4 global 01", {6'd2, 2'b01, 16'h0000});
        word_frame("R5 soft reset subset", {6'd6, 2'b11, 16'hFFFF});
        word_frame("R6 opcode 7 ignored", {6'd7, 2'b11, 16'h5555});
        word_frame("R6 opcode 63 ignored", {6'd63, 2'b11, 16'hAAAA});

        // R2: word fully shifted, chip select still low
        cs_n = 1'b0;
        tick(6);
        status_in = 24'hC00005;
        shift_bits(24, {24'h0, 6'd0, 2'b00, 16'h7E7E}, d);
        tick(10);
        chk("R2 held until deselect", out_on, e_on);
        chk("R8 status while held", miso_en, 1'b1);
        cs_n = 1'b1;
        tick(10);
        model_apply({6'd0, 2'b00, 16'h7E7E});
        chk("R2 applied on deselect", out_on, 16'h7E7E);

        // R7: miscounted selects
        frame(23, {25'h0, 6'd0, 2'b00, 15'h1111}, d);
        check_regs("R7 23 edges ignored");
        frame(25, {23'h0, 1'b0, 6'd0, 2'b00, 16'h2222}, d);
        check_regs("R7 25 edges ignored");
        cs_n = 1'b0;
        tick(12);
        cs_n = 1'b1;
        tick(10);
        check_regs("R7 zero edges ignored");

        // R10: clocking while deselected
        for (int i = 0; i < 5; i++) begin
            mosi = i[0];
            sck = 1'b1;
            tick(4);
            sck = 1'b0;
            tick(4);
            chk("R10 drive off while clocked", miso_en, 1'b0);
        end
        check_regs("R10 deselected clocks ignored");
        word_frame("R10 framing intact after idle clocks", {6'd5, 2'b00, 16'h00F0});

        // R9: daisy chain of two words
        status_in = 24'h9ABCDE;
        frame(48, {6'd0, 2'b00, 16'hDEAD, 6'd4, 2'b00, 16'hBEEF}, d);
        chk("R9 status first", d[47:24], 24'h9ABCDE);
        chk("R9 echo of first word", d[23:0], {6'd0, 2'b00, 16'hDEAD});
        model_apply({6'd4, 2'b00, 16'hBEEF});
        check_regs("R9 last word decoded");

        for (int k = 0; k < 40; k++) begin
            op = 6'($urandom_range(0, 8));
            if (op == 6'd8) op = 6'($urandom_range(7, 63));
            w = {op, 2'($urandom), 16'($urandom)};
            word_frame("R3 random word", w);
        end

        pin_rst_n = 1'b0;
        tick(2);
        pin_rst_n = 1'b1;
        tick(2);
        model_por();
        check_regs("R11 pin clear");

        word_frame("R3 write after pin clear", {6'd1, 2'b00, 16'hC3C3});
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(2);
        model_por();
        check_regs("R1 system reset again");

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule